// File: doc/BRIEF.md
# Page-mode DRAM access controller

This block sits between a simple processor bus request port and the control pins of a 16-bit DRAM. It splits each request address into an area index, a row and a column. It decides from a one-byte control register whether the area is DRAM. It then drives the row-address strobe, the two byte column strobes, the write strobe and the shared row/column address pins. Requests to any other area complete at once with zero read data and leave the DRAM pins alone.

With burst access enabled, a page stays open after an access. Later accesses to the same row strobe only the column. A row miss closes the page with a timed precharge first. A RAS-retention bit decides whether a non-DRAM access closes the open page or leaves RAS low. A standby input, together with the self-refresh bit, moves the DRAM into column-before-row self-refresh for as long as standby lasts. After that, normal access resumes after a fixed recovery.

Top module: `dram_page_ctrl`

## Requirements
- R1: Control field bits [7:5] hold the area-select value. While it is zero, any write stores the new value. While it is nonzero, a write stores its value only if that value is 000. Any other value is dropped and the field keeps its old content.
- R2: After reset the control register reads 8'h10. Bit 4 reads 1 whatever was written to it. Bit 0 reads 0. Bit 3 is burst enable, bit 2 is RAS retention and bit 1 is self-refresh enable.
- R3: With burst disabled, every DRAM access opens its own row (one falling RAS edge per access) and RAS rises once the access ends.
- R4: With burst enabled, an access whose row equals the open row while RAS is low makes no new falling RAS edge; only CAS is strobed.
- R5: A row miss, or a page close, holds RAS high for at least T_PRE cycles before the next row opens. A miss with the request held waiting gives exactly T_PRE+1 high cycles.
- R6: With burst enabled and RAS retention 1, a non-DRAM access leaves RAS low. With RAS retention 0, RAS goes high the cycle after that access.
- R7: When standby is requested with self-refresh enabled and a nonzero area field, both CAS lines go low one cycle before RAS falls. All three stay low for the whole standby period.
- R8: When standby ends, RAS rises first and both CAS lines rise one cycle later. The next row opens T_REC+1 cycles after CAS rises. Normal access resumes whatever self-refresh enable holds by then.
- R9: A standby request that arrives with a page open first raises RAS before self-refresh or idle standby begins. Standby has priority over a bus request presented in the same cycle.
- R10: req_be[1] selects the upper CAS line and data bits [15:8]. req_be[0] selects the lower CAS line and bits [7:0]. A byte write strobes only its own CAS line and changes only its own byte.
- R11: req_ready is high in the cycle the access completes. A DRAM read returns the word last written at that row and column. A non-DRAM access completes in the cycle it is presented, with read data 0.
- R12: The area index is req_addr[ADDR_W-1 -: 3], the row is the next ROW_W bits down and the column is the lowest COL_W bits. The area is DRAM when 2 <= index < 2 + area field.
- R13: While standby is requested without self-refresh, all DRAM pins stay inactive and no request completes until standby ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read-back |
| stby_req | input | 1 | Standby request, held high for the standby period |
| req_valid | input | 1 | Bus request valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: area, row, column |
| req_be | input | 2 | Byte enables, upper and lower |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Access completes this cycle |
| rsp_rdata | output | DATA_W | Read data, valid with req_ready |
| dram_ras_n | output | 1 | Row-address strobe, active low |
| dram_ucas_n | output | 1 | Upper-byte column strobe, active low |
| dram_lcas_n | output | 1 | Lower-byte column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_addr | output | MUX_W | Multiplexed row/column address |
| dram_dq_in | input | DATA_W | Data from DRAM |
| dram_dq_out | output | DATA_W | Data to DRAM |

## Verification
A standby request and a page-hit bus request can arrive in the same cycle while a page is held open. The bench raises both on the same falling clock edge, once with self-refresh enabled and once without. It judges the result on the pins: the page must close before the column-first entry, the pending access must not complete during standby, and the exit order and recovery gap must match. The access then finishes with the right data, even after self-refresh was cleared during standby.

// File: rtl/dram_pg_pkg.sv
// Shared types and constants for the page-mode DRAM controller.
// Assumes an 8-bit control register with a 3-bit area field.
package dram_pg_pkg;
    localparam int AREA_W    = 3;
    localparam int BASE_AREA = 2;

    typedef enum logic [3:0] {
        PG_IDLE,   // RAS high, no page open
        PG_ROW,    // RAS low, row address on pins
        PG_COL,    // CAS strobe, access completes
        PG_OPEN,   // page held open, waiting
        PG_PRE,    // precharge, RAS high for T_PRE cycles
        PG_SRCAS,  // self-refresh entry: CAS low first
        PG_SRON,   // self-refresh held
        PG_SRX1,   // self-refresh exit: RAS high, CAS still low
        PG_REC     // recovery wait after self-refresh
    } pg_state_e;
endpackage

// File: rtl/dram_pg_cfg.sv
// Control register: area field with write-once rule, burst, RAS retention
// and self-refresh flags. Assumes a single-cycle write strobe.
module dram_pg_cfg
    import dram_pg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic [AREA_W-1:0] area_sel,
    output logic              burst_en,
    output logic              ras_keep,
    output logic              sref_en
);
    logic [1:0] wr_unused;
    assign wr_unused = {wr_data[4], wr_data[0]};

    // Register update, area field only from zero or to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            area_sel <= '0;
            burst_en <= 1'b0;
            ras_keep <= 1'b0;
            sref_en  <= 1'b0;
        end else if (wr_en) begin
            if (area_sel == '0 || wr_data[7:5] == '0)
                area_sel <= wr_data[7:5];
            burst_en <= wr_data[3];
            ras_keep <= wr_data[2];
            sref_en  <= wr_data[1];
        end
    end

    // Read-back with the fixed bits.
    assign rd_data = {area_sel, 1'b1, burst_en, ras_keep, sref_en, 1'b0};

    p_area_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && area_sel != '0 && wr_data[7:5] != '0) |=> $stable(area_sel))
        else $error("R1 area field changed from nonzero to nonzero");
endmodule

// File: rtl/dram_pg_decode.sv
// Splits a request address into area, row and column, and decides whether
// the area is DRAM from the area field. Purely combinational.
module dram_pg_decode
    import dram_pg_pkg::*;
#(
    parameter int ROW_W = 8,
    parameter int COL_W = 8,
    localparam int ADDR_W = AREA_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [AREA_W-1:0] area_sel,
    output logic              is_dram,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    logic [AREA_W:0] idx_x;
    logic [AREA_W:0] lim_x;

    // Area range compare with one guard bit.
    always_comb begin
        idx_x   = {1'b0, addr[ADDR_W-1 -: AREA_W]};
        lim_x   = (AREA_W+1)'(BASE_AREA) + {1'b0, area_sel};
        is_dram = (area_sel != '0) && (idx_x >= (AREA_W+1)'(BASE_AREA)) && (idx_x < lim_x);
        row     = addr[COL_W +: ROW_W];
        col     = addr[COL_W-1:0];
    end
endmodule

// File: rtl/dram_pg_seq.sv
// Access sequencer: full and page-mode accesses, precharge, RAS retention,
// column-first self-refresh entry and exit. Assumes the requester holds
// its request stable until req_ready.
module dram_pg_seq
    import dram_pg_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int T_PRE  = 2,
    parameter int T_REC  = 4,
    localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int T_MAX = (T_PRE > T_REC) ? T_PRE : T_REC,
    localparam int CNT_W = $clog2(T_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              burst_en,
    input  logic              ras_keep,
    input  logic              sref_en,
    input  logic              area_any,
    input  logic              stby_req,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              is_dram,
    input  logic [ROW_W-1:0]  row,
    input  logic [COL_W-1:0]  col,
    input  logic [DATA_W-1:0] dq_in,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ras_n,
    output logic              ucas_n,
    output logic              lcas_n,
    output logic              we_n,
    output logic [MUX_W-1:0]  dram_addr,
    output logic [DATA_W-1:0] dq_out
);
    localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(T_PRE - 1);
    localparam logic [CNT_W-1:0] REC_LOAD = CNT_W'(T_REC - 1);

    pg_state_e         st, st_d;
    logic [CNT_W-1:0]  cnt, cnt_d;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic              wr_q;
    logic [1:0]        be_q;
    logic [DATA_W-1:0] wd_q;
    logic              take;
    logic              ack_nd;

    // Next-state selection; standby outranks bus requests.
    always_comb begin
        st_d   = st;
        cnt_d  = cnt;
        take   = 1'b0;
        ack_nd = 1'b0;
        case (st)
            PG_IDLE: begin
                if (stby_req) begin
                    if (sref_en && area_any) st_d = PG_SRCAS;
                end else if (req_valid) begin
                    if (is_dram) begin
                        take = 1'b1;
                        st_d = PG_ROW;
                    end else begin
                        ack_nd = 1'b1;
                    end
                end
            end
            PG_ROW: st_d = PG_COL;
            PG_COL: begin
                if (burst_en) begin
                    st_d = PG_OPEN;
                end else begin
                    st_d  = PG_PRE;
                    cnt_d = PRE_LOAD;
                end
            end
            PG_OPEN: begin
                if (stby_req || !burst_en) begin
                    st_d  = PG_PRE;
                    cnt_d = PRE_LOAD;
                end else if (req_valid) begin
                    if (is_dram && row == row_q) begin
                        take = 1'b1;
                        st_d = PG_COL;
                    end else if (is_dram) begin
                        st_d  = PG_PRE;
                        cnt_d = PRE_LOAD;
                    end else begin
                        ack_nd = 1'b1;
                        if (!ras_keep) begin
                            st_d  = PG_PRE;
                            cnt_d = PRE_LOAD;
                        end
                    end
                end
            end
            PG_PRE, PG_REC: begin
                if (cnt == '0) st_d = PG_IDLE;
                else           cnt_d = cnt - 1'b1;
            end
            PG_SRCAS: st_d = PG_SRON;
            PG_SRON:  if (!stby_req) st_d = PG_SRX1;
            PG_SRX1: begin
                st_d  = PG_REC;
                cnt_d = REC_LOAD;
            end
            default: st_d = PG_IDLE;
        endcase
    end

    // State and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= PG_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_d;
            cnt <= cnt_d;
        end
    end

    // Request capture when an access is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            col_q <= '0;
            wr_q  <= 1'b0;
            be_q  <= 2'b00;
            wd_q  <= '0;
        end else if (take) begin
            row_q <= row;
            col_q <= col;
            wr_q  <= req_write;
            be_q  <= req_be;
            wd_q  <= req_wdata;
        end
    end

    logic sr_cas;
    // Pin decode from the current state.
    always_comb begin
        sr_cas    = (st == PG_SRCAS) || (st == PG_SRON) || (st == PG_SRX1);
        ras_n     = !((st == PG_ROW) || (st == PG_COL) || (st == PG_OPEN) || (st == PG_SRON));
        ucas_n    = !(((st == PG_COL) && be_q[1]) || sr_cas);
        lcas_n    = !(((st == PG_COL) && be_q[0]) || sr_cas);
        we_n      = !((st == PG_COL) && wr_q);
        dram_addr = (st == PG_ROW) ? MUX_W'(row_q) : MUX_W'(col_q);
        dq_out    = wd_q;
        req_ready = (st == PG_COL) || ack_nd;
        rsp_rdata = (st == PG_COL) ? dq_in : '0;
    end

    p_full_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PG_COL && !burst_en) |=> ras_n)
        else $error("R3 RAS still low after a full access");

    p_keep_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PG_OPEN && burst_en && ras_keep && req_valid && !is_dram && !stby_req) |=> !ras_n)
        else $error("R6 page lost on a non-DRAM access");

    p_cbr_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !ucas_n && !lcas_n) |-> $past(ras_n && !ucas_n && !lcas_n))
        else $error("R7 CAS did not lead RAS on refresh entry");

    p_sr_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ras_n) && !ucas_n && !lcas_n) |=> (ras_n && ucas_n && lcas_n))
        else $error("R8 CAS did not follow RAS on refresh exit");

    p_stby_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PG_IDLE && stby_req) |-> !req_ready)
        else $error("R13 access completed during standby");
endmodule

// File: rtl/dram_page_ctrl.sv
// Top of the page-mode DRAM controller: control register, address decode
// and access sequencer. Assumes one DRAM of 2^(ROW_W+COL_W) 16-bit words.
module dram_page_ctrl
    import dram_pg_pkg::*;
#(
    parameter int ROW_W  = 8,
    parameter int COL_W  = 8,
    parameter int DATA_W = 16,
    parameter int T_PRE  = 2,
    parameter int T_REC  = 4,
    localparam int ADDR_W = AREA_W + ROW_W + COL_W,
    localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              stby_req,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_be,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              dram_ras_n,
    output logic              dram_ucas_n,
    output logic              dram_lcas_n,
    output logic              dram_we_n,
    output logic [MUX_W-1:0]  dram_addr,
    input  logic [DATA_W-1:0] dram_dq_in,
    output logic [DATA_W-1:0] dram_dq_out
);
    logic [AREA_W-1:0] area_sel;
    logic              burst_en, ras_keep, sref_en, is_dram;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;

    dram_pg_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_data(cfg_wdata),
        .rd_data(cfg_rdata), .area_sel(area_sel), .burst_en(burst_en),
        .ras_keep(ras_keep), .sref_en(sref_en)
    );

    dram_pg_decode #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
        .addr(req_addr), .area_sel(area_sel), .is_dram(is_dram),
        .row(row), .col(col)
    );

    dram_pg_seq #(
        .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
        .T_PRE(T_PRE), .T_REC(T_REC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .ras_keep(ras_keep),
        .sref_en(sref_en), .area_any(area_sel != '0), .stby_req(stby_req),
        .req_valid(req_valid), .req_write(req_write), .req_be(req_be),
        .req_wdata(req_wdata), .is_dram(is_dram), .row(row), .col(col),
        .dq_in(dram_dq_in), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .ras_n(dram_ras_n), .ucas_n(dram_ucas_n), .lcas_n(dram_lcas_n),
        .we_n(dram_we_n), .dram_addr(dram_addr), .dq_out(dram_dq_out)
    );
endmodule

// File: tb/sim_dram_page_ctrl.sv
`timescale 1ns/1ps
module sim_dram_page_ctrl;
    localparam int RW = 4, CW = 4, AW = 3 + RW + CW;
    localparam int TP = 2, TR = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic stby_req = 1'b0, req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_be = 2'b11;
    logic [15:0] req_wdata = '0, rsp_rdata, dq_in, dq_out;
    logic req_ready, ras_n, ucas_n, lcas_n, we_n;
    logic [3:0] daddr;

    always #2.5 clk = ~clk;

    dram_page_ctrl #(.ROW_W(RW), .COL_W(CW), .DATA_W(16), .T_PRE(TP), .T_REC(TR)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .stby_req(stby_req), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
        .dram_ras_n(ras_n), .dram_ucas_n(ucas_n), .dram_lcas_n(lcas_n),
        .dram_we_n(we_n), .dram_addr(daddr), .dram_dq_in(dq_in), .dram_dq_out(dq_out)
    );

    // DRAM pin model and pin monitor, all sampled on the falling edge.
    logic [15:0] mem [256];
    logic [15:0] ref_m [256];
    logic [3:0] row_m = '0;
    logic p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1, mon_clr = 1'b0;
    int cyc = 0, rise_cyc = 0, ras_falls = 0, cbr_good = 0, cbr_bad = 0;
    int last_hi = 0, min_hi = 1000000, exit_cyc = 0, cas_gap = 0, rec_gap = 0, rec_start = 0;
    bit exit_pend = 0, rec_pend = 0, u_wr = 0, l_wr = 0;

    assign dq_in = mem[{row_m, daddr}];

    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            ras_falls = 0; cbr_good = 0; cbr_bad = 0; u_wr = 0; l_wr = 0;
        end
        if (rst_n) begin
            if (p_ras && !ras_n) begin
                if (!ucas_n && !lcas_n) begin
                    if (p_ras && !p_u && !p_l) cbr_good++; else cbr_bad++;
                end else begin
                    ras_falls++;
                    row_m = daddr;
                    last_hi = cyc - rise_cyc;
                    if (last_hi < min_hi) min_hi = last_hi;
                    if (rec_pend) begin rec_gap = cyc - rec_start; rec_pend = 0; end
                end
            end
            if (!p_ras && ras_n) begin
                rise_cyc = cyc;
                if (!ucas_n && !lcas_n) begin exit_cyc = cyc; exit_pend = 1; end
            end
            if (!p_u && !p_l && ucas_n && lcas_n && exit_pend) begin
                cas_gap = cyc - exit_cyc; exit_pend = 0; rec_pend = 1; rec_start = cyc;
            end
            if (!ras_n && !we_n) begin
                if (!ucas_n) begin mem[{row_m, daddr}][15:8] = dq_out[15:8]; u_wr = 1; end
                if (!lcas_n) begin mem[{row_m, daddr}][7:0] = dq_out[7:0]; l_wr = 1; end
            end
        end
        p_ras = ras_n; p_u = ucas_n; p_l = lcas_n;
    end

    int n_chk = 0, n_fail = 0;
    bit acc_done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit dram_f(input logic [AW-1:0] a);
        return (a[AW-1 -: 3] >= 3'd2) && (a[AW-1 -: 3] < 3'd4);
    endfunction

    function automatic logic [15:0] merge_f(input logic [15:0] o, input logic [15:0] n, input logic [1:0] be);
        return {be[1] ? n[15:8] : o[15:8], be[0] ? n[7:0] : o[7:0]};
    endfunction

    function automatic logic [AW-1:0] mk(input int area, input int row, input int col);
        return {3'(area), 4'(row), 4'(col)};
    endfunction

    task automatic cfg_wr(input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(posedge clk); #1; cfg_we = 1'b0;
    endtask

    task automatic clr_mon();
        @(posedge clk); mon_clr = 1'b1;
        @(posedge clk); mon_clr = 1'b0;
    endtask

    task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] be,
                          input logic [15:0] wd, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        rd = rsp_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (wr && dram_f(a)) ref_m[a[7:0]] = merge_f(ref_m[a[7:0]], wd, be);
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input string tag);
        logic [15:0] r;
        logic [15:0] e;
        access(1'b0, a, 2'b11, 16'h0, r);
        e = dram_f(a) ? ref_m[a[7:0]] : 16'h0;
        chk(r == e, tag, r, e);
    endtask

    task automatic run();
        logic [15:0] r;
        int f0;
        for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cfg_rdata == 8'h10, "R2 reset readback", cfg_rdata, 8'h10);
        chk(ras_n && ucas_n && lcas_n && we_n, "R2 pins idle after reset", {ras_n, ucas_n, lcas_n, we_n}, 4'hF);

        // R1 write-once area field, R2 fixed bits
        cfg_wr(8'h40); #1 chk(cfg_rdata == 8'h50, "R1 first area write", cfg_rdata, 8'h50);
        cfg_wr(8'hA0); #1 chk(cfg_rdata == 8'h50, "R1 nonzero rewrite ignored", cfg_rdata, 8'h50);
        cfg_wr(8'h01); #1 chk(cfg_rdata == 8'h10, "R1 clear to zero, R2 bit0 reads 0", cfg_rdata, 8'h10);
        cfg_wr(8'h40); #1 chk(cfg_rdata == 8'h50, "R2 bit4 reads 1", cfg_rdata, 8'h50);

        // R3 full accesses
        clr_mon();
        access(1'b1, mk(2, 5, 3), 2'b11, 16'h1234, r);
        rd_chk(mk(2, 5, 3), "R11 read after write");
        chk(ras_falls == 2, "R3 one row open per access", ras_falls, 2);
        @(negedge clk); chk(ras_n, "R3 RAS high after access", ras_n, 1);

        // R4 page hit, R5 miss
        cfg_wr(8'h48);
        clr_mon();
        access(1'b1, mk(2, 6, 1), 2'b11, 16'hBEEF, r);
        rd_chk(mk(2, 6, 1), "R4 hit read data");
        access(1'b1, mk(3, 6, 9), 2'b11, 16'hCAFE, r);
        chk(ras_falls == 1, "R4 no new row on hit", ras_falls, 1);
        rd_chk(mk(2, 7, 2), "R5 miss read data");
        chk(last_hi == TP + 1, "R5 precharge width", last_hi, TP + 1);

        // R6 RAS retention
        cfg_wr(8'h4C);
        rd_chk(mk(2, 7, 3), "R4 hit after mode change");
        rd_chk(mk(0, 7, 3), "R11 non-DRAM returns 0");
        repeat (3) @(negedge clk);
        #1 chk(!ras_n, "R6 RAS kept low", ras_n, 0);
        clr_mon();
        rd_chk(mk(2, 7, 4), "R6 kept page usable");
        chk(ras_falls == 0, "R6 no reopen", ras_falls, 0);
        cfg_wr(8'h48);
        rd_chk(mk(1, 0, 0), "R11 non-DRAM RAS-up");
        @(negedge clk); #1 chk(ras_n, "R6 RAS up after non-DRAM", ras_n, 1);

        // R10 byte strobes
        access(1'b1, mk(2, 9, 9), 2'b11, 16'hA5A5, r);
        clr_mon();
        access(1'b1, mk(2, 9, 9), 2'b01, 16'h3C3C, r);
        chk(!u_wr && l_wr, "R10 only lower CAS", {u_wr, l_wr}, 2'b01);
        rd_chk(mk(2, 9, 9), "R10 lower byte merge");
        access(1'b1, mk(2, 9, 9), 2'b10, 16'h7E00, r);
        chk(ref_m[8'h99] == 16'h7E3C, "R10 reference merge", ref_m[8'h99], 16'h7E3C);
        rd_chk(mk(2, 9, 9), "R10 upper byte merge");

        // R12 decode
        clr_mon();
        rd_chk(mk(4, 9, 9), "R12 area 4 not DRAM");
        chk(ras_falls == 0, "R12 no row for area 4", ras_falls, 0);
        rd_chk(mk(3, 9, 9), "R12 area 3 aliases DRAM");

        // R7 R8 R9: standby with self-refresh, together with a page hit
        cfg_wr(8'h4E);
        rd_chk(mk(2, 9, 1), "R4 page open before standby");
        clr_mon();
        acc_done = 0;
        fork
            begin
                access(1'b0, mk(2, 9, 9), 2'b11, 16'h0, r);
                acc_done = 1;
                chk(r == ref_m[8'h99], "R8 access after exit", r, ref_m[8'h99]);
            end
            begin
                @(negedge clk); stby_req = 1'b1;
                repeat (10) @(negedge clk);
                #1 chk(!ras_n && !ucas_n && !lcas_n, "R7 self-refresh held", {ras_n, ucas_n, lcas_n}, 0);
                chk(cbr_good == 1 && cbr_bad == 0, "R7 R9 column-first entry after close", cbr_good, 1);
                chk(!acc_done, "R9 standby outranks request", acc_done, 0);
                cfg_wr(8'h48);
                @(negedge clk); stby_req = 1'b0;
            end
        join
        chk(cas_gap == 1, "R8 CAS rises one cycle after RAS", cas_gap, 1);
        chk(rec_gap == TR + 1, "R8 recovery gap", rec_gap, TR + 1);

        // R13 standby without self-refresh
        rd_chk(mk(2, 4, 4), "R13 page open before standby");
        acc_done = 0;
        fork
            begin
                access(1'b1, mk(2, 4, 5), 2'b11, 16'h5A5A, r);
                acc_done = 1;
            end
            begin
                @(negedge clk); stby_req = 1'b1;
                repeat (8) @(negedge clk);
                #1 chk(ras_n && ucas_n && lcas_n && we_n, "R13 pins idle in standby", {ras_n, ucas_n, lcas_n, we_n}, 4'hF);
                chk(!acc_done, "R13 request held", acc_done, 0);
                stby_req = 1'b0;
            end
        join
        rd_chk(mk(2, 4, 5), "R13 write after standby");

        // Random traffic with mode changes and short standby pulses
        void'($urandom(32'd1357));
        for (int i = 0; i < 400; i++) begin
            int k;
            k = $urandom % 20;
            if (k == 0) begin
                cfg_wr({3'd2, 1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0});
            end else if (k == 1) begin
                @(negedge clk); stby_req = 1'b1;
                repeat (2 + $urandom % 4) @(negedge clk);
                stby_req = 1'b0;
            end else begin
                logic [AW-1:0] a;
                a = mk(($urandom % 3 == 0) ? $urandom % 8 : 2 + $urandom % 2, $urandom % 4, $urandom % 16);
                if ($urandom % 2) begin
                    logic [1:0] be;
                    be = 2'(1 + $urandom % 3);
                    access(1'b1, a, be, 16'($urandom), r);
                end else begin
                    rd_chk(a, "R11 random read");
                end
            end
        end
        f0 = min_hi;
        chk(f0 >= TP, "R5 minimum RAS high time", f0, TP);
        chk(cbr_bad == 0, "R7 no out-of-order refresh entry", cbr_bad, 0);
    endtask

    initial begin
        fork
            run();
            begin
                #(200000 * 5);
                n_chk++; n_fail++;
                $display("FAIL R11 watchdog actual=timeout expected=completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule